// File: doc/BRIEF.md
# Speculative Load Ordering Violation Detector

An out-of-order core may let a load take its value before older loads have done so. That is safe only if no other agent writes the location before the load retires. This block keeps a circular queue of in-flight loads in program order. Each entry is created at dispatch, marked complete with its cache-line address when the load obtains data, and released from the head when the load retires. Every coherence invalidation is compared against all completed, unretired entries at once. When one or more entries hold the invalidated line, the block requests a squash that names the oldest of them. In the same cycle it removes that entry and everything younger, so the core can refetch from that load onward.

A load's sequence tag is its queue slot plus one wrap bit, so tags run modulo twice the queue depth. Age is measured as distance from the head, which stays correct when the queue wraps. The block only detects and reports. Re-execution, refetch and the cache are left to the surrounding core.

Top module: `load_order_guard`

## Requirements
- R1: After reset the queue is empty, `alloc_ready` is 1, `alloc_tag` is 0 and `squash_valid` is 0.
- R2: A tag has TAG_W = log2(DEPTH)+1 bits. The low log2(DEPTH) bits are the slot and the top bit is the wrap bit. Each accepted allocation takes the tag on `alloc_tag`, and `alloc_tag` then advances by one modulo 2*DEPTH. `alloc_ready` is 0 while DEPTH loads are held, and a request made then is ignored.
- R3: A completion stores the line address (address divided by LINE_BYTES) for the queued load with that tag. A completion for a tag not in the queue is ignored. A load that has not completed never matches an invalidation.
- R4: When `inv_valid` is high and the invalidated line equals the line of a completed queued load, `squash_valid` is 1 for exactly the next cycle. Addresses within the same line match. Addresses in other lines do not match.
- R5: When several completed loads match, `squash_tag` is the tag of the oldest, by program order counted from the head, including after wrap-around.
- R6: A squash removes the reported load and every younger load in the same cycle. The next `alloc_tag` equals `squash_tag`, and an allocation requested in the squash cycle is dropped.
- R7: `retire_valid` frees the head load only if the head has completed. It is ignored when the head has not completed or the queue is empty.
- R8: An invalidation is compared against the state before the clock edge, so a completion in the same cycle is not matched. A retire in a squash cycle proceeds only if the head is not itself squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate the next load in program order |
| alloc_ready | output | 1 | Queue has a free slot |
| alloc_tag | output | TAG_W | Tag the next allocation receives |
| cmpl_valid | input | 1 | A load obtained its value |
| cmpl_tag | input | TAG_W | Tag of the completing load |
| cmpl_addr | input | ADDR_W | Byte address the load read |
| retire_valid | input | 1 | Retire the oldest load |
| inv_valid | input | 1 | External invalidation present |
| inv_addr | input | ADDR_W | Invalidated byte address |
| squash_valid | output | 1 | One-cycle squash request |
| squash_tag | output | TAG_W | Tag of the oldest violating load |

## Verification
The hardest case to reach is an invalidation that hits several completed loads while the queue has wrapped. In that case the oldest match sits in a higher slot than younger matches, and a plain lowest-index pick would be wrong. Directed steps complete loads out of order to the same line before invalidating it. A long random phase then keeps allocating, retiring and squashing over a pool of four lines, which carries the head across the wrap point many times with several matching entries live. Same-cycle collisions are set up on purpose: a completion with an invalidation, a retire with a squash of the head, and an allocation with a squash.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  // Life cycle of one queue slot
  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,
    ENT_WAIT = 2'd1,
    ENT_DONE = 2'd2
  } ent_st_e;
endpackage

// File: rtl/lvd_line_cmp.sv
module lvd_line_cmp #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26
) (
  input  lvd_pkg::ent_st_e [DEPTH-1:0]             st_i,
  input  logic             [DEPTH-1:0][LINE_W-1:0] line_i,
  input  logic                                     inv_valid_i,
  input  logic             [LINE_W-1:0]            inv_line_i,
  output logic             [DEPTH-1:0]             hit_o
);
  // One comparator per slot, all evaluated in parallel
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_o[g] = inv_valid_i && (st_i[g] == lvd_pkg::ENT_DONE) &&
                      (line_i[g] == inv_line_i);
  end
endmodule

// File: rtl/lvd_oldest_pick.sv
module lvd_oldest_pick #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] hit_i,
  input  logic [IDX_W-1:0] head_idx_i,
  output logic             found_o,
  output logic [IDX_W-1:0] off_o,
  output logic [DEPTH-1:0] sel_oh_o
);
  // Scan from the head outward; the first hit is the oldest (DEPTH is a power of two)
  always_comb begin
    logic [IDX_W-1:0] idx;
    found_o  = 1'b0;
    off_o    = '0;
    sel_oh_o = '0;
    idx      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_idx_i + IDX_W'(k);
      if (!found_o && hit_i[idx]) begin
        found_o       = 1'b1;
        off_o         = IDX_W'(k);
        sel_oh_o[idx] = 1'b1;
      end
    end
  end

  p_pick_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh_o));
  p_pick_is_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> hit_i[head_idx_i + off_o]);
  p_pick_head_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i[head_idx_i] |-> (off_o == '0));
endmodule

// File: rtl/lvd_ptrs.sv
module lvd_ptrs #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic             retire_i,
  input  logic             squash_i,
  input  logic [TAG_W-1:0] squash_tag_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic [TAG_W-1:0] count_o
);
  logic [TAG_W-1:0] head_d, tail_d;
  logic             head_en, tail_en;

  always_comb begin
    head_en = retire_i;
    head_d  = head_o + TAG_W'(1);
    tail_en = squash_i || alloc_i;
    tail_d  = squash_i ? squash_tag_i : (tail_o + TAG_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_o <= '0;
      tail_o <= '0;
    end else begin
      if (head_en) head_o <= head_d;
      if (tail_en) tail_o <= tail_d;
    end
  end

  assign count_o = tail_o - head_o;

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= TAG_W'(DEPTH));
  p_head_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (head_o == $past(head_o)) || (head_o == $past(head_o) + TAG_W'(1)));
endmodule

// File: rtl/load_order_guard.sv
module load_order_guard #(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int TAG_W      = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cmpl_valid,
  input  logic [TAG_W-1:0]  cmpl_tag,
  input  logic [ADDR_W-1:0] cmpl_addr,
  input  logic              retire_valid,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              squash_valid,
  output logic [TAG_W-1:0]  squash_tag
);
  import lvd_pkg::*;

  localparam int IDX_W  = TAG_W - 1;
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFS_W;

  ent_st_e [DEPTH-1:0]             st_q, st_d;
  logic    [DEPTH-1:0][TAG_W-1:0]  tag_q, tag_d;
  logic    [DEPTH-1:0][LINE_W-1:0] line_q, line_d;

  logic [TAG_W-1:0] head_q, tail_q, count;
  logic [IDX_W-1:0] head_idx, tail_idx, cmpl_idx, pick_off;
  logic [DEPTH-1:0] hit, pick_oh;
  logic             hit_any;
  logic [TAG_W-1:0] hit_tag;
  logic             alloc_do, retire_do, cmpl_do;
  logic             sq_v_q;
  logic [TAG_W-1:0] sq_tag_q;
  logic             unused_ofs;

  assign unused_ofs = ^{cmpl_addr[OFS_W-1:0], inv_addr[OFS_W-1:0], pick_oh};

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign cmpl_idx = cmpl_tag[IDX_W-1:0];

  lvd_line_cmp #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_cmp (
    .st_i        (st_q),
    .line_i      (line_q),
    .inv_valid_i (inv_valid),
    .inv_line_i  (inv_addr[ADDR_W-1:OFS_W]),
    .hit_o       (hit)
  );

  lvd_oldest_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit),
    .head_idx_i (head_idx),
    .found_o    (hit_any),
    .off_o      (pick_off),
    .sel_oh_o   (pick_oh)
  );

  assign hit_tag = head_q + TAG_W'(pick_off);

  lvd_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ptrs (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_i      (alloc_do),
    .retire_i     (retire_do),
    .squash_i     (hit_any),
    .squash_tag_i (hit_tag),
    .head_o       (head_q),
    .tail_o       (tail_q),
    .count_o      (count)
  );

  assign alloc_ready = (count != TAG_W'(DEPTH));
  assign alloc_tag   = tail_q;

  // Control decisions all use the state before the edge
  always_comb begin
    alloc_do  = alloc_valid && alloc_ready && !hit_any;
    retire_do = retire_valid && (count != '0) && (st_q[head_idx] == ENT_DONE) &&
                !(hit_any && (pick_off == '0));
    cmpl_do   = cmpl_valid && (st_q[cmpl_idx] != ENT_FREE) && (tag_q[cmpl_idx] == cmpl_tag);
  end

  // Per-slot next state; later rules take priority
  always_comb begin
    logic [IDX_W-1:0] age;
    st_d   = st_q;
    tag_d  = tag_q;
    line_d = line_q;
    age    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      age = IDX_W'(i) - head_idx;
      if (alloc_do && (tail_idx == IDX_W'(i))) begin
        st_d[i]  = ENT_WAIT;
        tag_d[i] = tail_q;
      end
      if (cmpl_do && (cmpl_idx == IDX_W'(i))) begin
        st_d[i]   = ENT_DONE;
        line_d[i] = cmpl_addr[ADDR_W-1:OFS_W];
      end
      if (retire_do && (head_idx == IDX_W'(i))) begin
        st_d[i] = ENT_FREE;
      end
      if (hit_any && (st_q[i] != ENT_FREE) && (age >= pick_off)) begin
        st_d[i] = ENT_FREE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= {DEPTH{ENT_FREE}};
      tag_q  <= '0;
      line_q <= '0;
    end else begin
      st_q   <= st_d;
      tag_q  <= tag_d;
      line_q <= line_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_v_q   <= 1'b0;
      sq_tag_q <= '0;
    end else begin
      sq_v_q <= hit_any;
      if (hit_any) sq_tag_q <= hit_tag;
    end
  end

  assign squash_valid = sq_v_q;
  assign squash_tag   = sq_tag_q;

  p_squash_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> $past(inv_valid));
  p_squash_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> (alloc_tag == squash_tag));
  p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready && !hit_any) |=> (alloc_tag == $past(alloc_tag)));
  p_retire_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[head_idx] != ENT_DONE) |=> (head_q == $past(head_q)));
  p_squash_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |=> (st_q[$past(hit_tag[IDX_W-1:0])] == ENT_FREE));
endmodule

// File: tb/load_order_guard_test.sv
module load_order_guard_test;
  localparam int DEPTH = 8;
  localparam int TW    = 4;

  logic clk, rst_n;
  logic av, cv, rv, iv;
  logic [TW-1:0] ctag;
  logic [31:0]   caddr, iaddr;
  logic          alloc_ready, squash_valid;
  logic [TW-1:0] alloc_tag, squash_tag;

  load_order_guard uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(av), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmpl_valid(cv), .cmpl_tag(ctag), .cmpl_addr(caddr),
    .retire_valid(rv), .inv_valid(iv), .inv_addr(iaddr),
    .squash_valid(squash_valid), .squash_tag(squash_tag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct { int tag; bit done; int line; } ment_t;
  ment_t mq[$];
  int    m_tail;
  bit    e_sv;
  int    e_st;
  int    nvec, nfail;
  bit    ended;
  string cur_req;

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  task automatic chk(string what, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  // Reference update at a clock edge, from pre-edge state and current inputs
  task automatic model_edge();
    int  k, pre_size, cp;
    bit  head_done;
    k = -1;
    pre_size  = mq.size();
    head_done = (pre_size > 0) && mq[0].done;
    if (iv) begin
      for (int p = 0; p < pre_size; p++)
        if (k < 0 && mq[p].done && mq[p].line == int'(iaddr >> 6)) k = p;
    end
    e_sv = (k >= 0);
    if (k >= 0) e_st = mq[k].tag;
    if (cv) begin
      cp = -1;
      for (int p = 0; p < pre_size; p++) if (mq[p].tag == int'(ctag)) cp = p;
      if (cp >= 0 && (k < 0 || cp < k)) begin
        mq[cp].done = 1'b1;
        mq[cp].line = int'(caddr >> 6);
      end
    end
    if (k >= 0) begin
      while (mq.size() > k) void'(mq.pop_back());
      m_tail = e_st;
    end
    if (rv && head_done && k != 0) void'(mq.pop_front());
    if (k < 0 && av && pre_size < DEPTH) begin
      ment_t n;
      n.tag = m_tail; n.done = 1'b0; n.line = 0;
      mq.push_back(n);
      m_tail = (m_tail + 1) % (2 * DEPTH);
    end
  endtask

  task automatic compare();
    chk("alloc_ready", int'(alloc_ready), int'(mq.size() < DEPTH));
    chk("alloc_tag", int'(alloc_tag), m_tail);
    chk("squash_valid", int'(squash_valid), int'(e_sv));
    if (e_sv) chk("squash_tag", int'(squash_tag), e_st);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    av = 0; cv = 0; rv = 0; iv = 0;
  endtask

  task automatic go(bit a, bit c, int ct, int ca, bit r, bit i, int ia);
    av = a; cv = c; ctag = TW'(ct); caddr = ca; rv = r; iv = i; iaddr = ia;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    nvec = 0; nfail = 0; ended = 0; m_tail = 0; e_sv = 0; e_st = 0;
    av = 0; cv = 0; rv = 0; iv = 0; ctag = '0; caddr = '0; iaddr = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    compare();
    go(0,0,0,0,0,0,0);

    cur_req = "R2";                                   // fill, then one refused request
    for (int n = 0; n < DEPTH; n++) go(1,0,0,0,0,0,0);
    go(1,0,0,0,0,0,0);

    cur_req = "R3";                                   // out-of-order completions; waiting loads do not match
    go(0,1,5,32'h1000,0,0,0);
    go(0,1,2,32'h2000,0,0,0);
    go(0,0,0,0,0,1,32'h3000);
    go(0,1,12,32'h3000,0,0,0);                        // stale tag ignored
    go(0,0,0,0,0,1,32'h3000);

    cur_req = "R4";                                   // same line, other byte
    go(0,0,0,0,0,1,32'h103C);
    go(0,0,0,0,0,1,32'h2040);

    cur_req = "R5";                                   // three matches, oldest reported
    go(0,1,4,32'h2010,0,0,0);
    go(0,1,1,32'h2030,0,0,0);
    go(0,0,0,0,0,1,32'h2000);

    cur_req = "R6";                                   // allocation in squash cycle dropped
    go(1,0,0,0,0,0,0);
    go(0,1,1,32'h4000,0,0,0);
    go(1,0,0,0,0,1,32'h4000);
    go(1,0,0,0,0,0,0);

    cur_req = "R7";                                   // retire of waiting head ignored
    go(0,0,0,0,1,0,0);
    go(0,1,0,32'h5000,0,0,0);
    go(0,0,0,0,0,1,32'h5000);
    go(1,0,0,0,0,0,0);
    go(0,1,0,32'h5000,0,0,0);
    go(0,0,0,0,1,0,0);
    go(0,0,0,0,0,1,32'h5000);
    go(0,0,0,0,1,0,0);                                // empty queue

    cur_req = "R8";                                   // same-cycle completion not matched
    go(1,0,0,0,0,0,0);
    go(0,1,1,32'h6000,0,1,32'h6000);
    go(0,0,0,0,0,1,32'h6000);
    go(1,0,0,0,0,0,0);
    go(1,0,0,0,0,0,0);
    go(0,1,1,32'h7000,0,0,0);
    go(0,1,2,32'h7000,0,0,0);
    go(0,0,0,0,1,1,32'h7000);                         // head squashed, retire dropped
    go(1,0,0,0,0,0,0);
    go(1,0,0,0,0,0,0);
    go(0,1,1,32'h8000,0,0,0);
    go(0,1,2,32'h7000,0,0,0);
    go(0,0,0,0,1,1,32'h7000);                         // head retires, younger squashed

    cur_req = "R5 wrap mix";
    for (int n = 0; n < 4000; n++) begin
      int pick;
      av = ($urandom_range(0, 9) < 6);
      rv = ($urandom_range(0, 9) < 3);
      iv = ($urandom_range(0, 99) < 8);
      iaddr = ((32'h100 + $urandom_range(0, 3)) << 6) | $urandom_range(0, 63);
      cv = 0;
      if (mq.size() > 0 && $urandom_range(0, 1) == 1) begin
        pick = $urandom_range(0, mq.size() - 1);
        if (!mq[pick].done) begin
          cv = 1;
          ctag = TW'(mq[pick].tag);
          caddr = ((32'h100 + $urandom_range(0, 3)) << 6) | $urandom_range(0, 63);
        end
      end
      step();
    end

    finish_up();
  end
endmodule